// File: doc/BRIEF.md
# Pseudo-Random Test Pattern Source with Manchester Line Coding

This block produces the stimulus for a baseband link under test. A four-stage linear feedback shift register generates a maximal-length data pattern. Each data bit goes out on the line as two half-bit symbols in Manchester form. A separate twelve-stage shift register generates an unrelated pseudo-random bit stream, which an analog stage outside the block scales and adds to the line as interference.

Timing comes from a single enable, `halfEn`, that pulses at twice the bit rate. An internal half-bit phase alternates between the first and second half of a bit on each pulse. Both shift registers advance on the pulse that closes the second half, so the data bit, the noise bit and the line symbol all stay aligned to one bit grid. The seeds and tap sets are parameters fixed at elaboration.

Top module: `prbs_manch_src`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads its seeds: data register 4'b1000 (its MSB drives `dataOut`) and noise register 12'h800 (its MSB drives `noiseOut`), with the phase in the first half. Right after reset, `dataOut`=1, `noiseOut`=1 and `lineOut`=1.
- R2: The `dataOut` sequence, one value per bit, obeys d[n+4] = d[n] XOR d[n+1] (generator 1 + x^3 + x^4). After reset it starts 1,0,0,0,1,0,0,1,1,0,1,0,1,1,1, repeats every 15 bits and holds eight ones per period.
- R3: In the first half of a bit, `lineOut` equals `dataOut`. In the second half it equals the inverse. A 1 is therefore sent high-then-low and a 0 low-then-high.
- R4: The first `halfEn` pulse of a bit only moves the phase to the second half, leaving `dataOut` and `noiseOut` unchanged. The second pulse advances both registers and returns the phase to the first half. Each change shows one clock after the enabling edge.
- R5: With `halfEn` low, all three outputs hold their values.
- R6: The `noiseOut` sequence obeys m[n+12] = m[n] XOR m[n+6] XOR m[n+8] XOR m[n+11]. It repeats every 4095 bits and holds 2048 ones per period.
- R7: Reset has priority over `halfEn` and restores the R1 state from any phase, including the middle of a bit.
- R8: Neither shift register ever reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Working clock |
| rst | input | 1 | Synchronous reset, active high |
| halfEn | input | 1 | One-cycle enable at twice the bit rate |
| dataOut | output | 1 | Raw pseudo-random data bit |
| lineOut | output | 1 | Manchester-coded line symbol |
| noiseOut | output | 1 | Pseudo-random interferer bit |

## Verification
Every result settles one clock after the edge that samples `halfEn` high: the line phase on each pulse, the data and noise bits on every second pulse. Reset takes effect on the edge where it is sampled. The bench drives `halfEn` for exactly one cycle from a falling edge and reads the outputs at the next falling edge, after exactly one rising edge. It then reads each bit twice: once in the first half and once in the second.

// File: rtl/prbs_manch_pkg.sv
package prbs_manch_pkg;
  typedef struct packed {
    logic toggle;   // half-bit boundary: flip line phase
    logic advance;  // bit boundary: shift both registers
  } strobes_t;
endpackage

// File: rtl/prbs_manch_lfsr.sv
module prbs_manch_lfsr #(
  parameter int          WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS = 4'b1100,
  parameter logic [WIDTH-1:0] SEED = 4'b1000
) (
  input  logic clk,
  input  logic rst,
  input  logic shiftEn,
  output logic msb
);
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] nextState;

  assign nextState[0] = ^(state & TAPS);
  for (genvar i = 1; i < WIDTH; i++) begin : g_shift
    assign nextState[i] = state[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= SEED;
    else if (shiftEn) state <= nextState;
  end

  assign msb = state[WIDTH-1];

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shiftEn |=> $stable(state)); // R5
endmodule

// File: rtl/prbs_manch_ctrl.sv
module prbs_manch_ctrl
  import prbs_manch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     halfEn,
  output strobes_t stb,
  output logic     phase
);
  always_ff @(posedge clk) begin
    if (rst)         phase <= 1'b0;
    else if (halfEn) phase <= ~phase;
  end

  assign stb.toggle  = halfEn;
  assign stb.advance = halfEn & phase;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !halfEn |=> $stable(phase)); // R5
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    halfEn |=> phase != $past(phase)); // R4
endmodule

// File: rtl/prbs_manch_dp.sv
module prbs_manch_dp
  import prbs_manch_pkg::*;
#(
  parameter int DATA_WIDTH  = 4,
  parameter logic [DATA_WIDTH-1:0]  DATA_TAPS  = 4'b1100,
  parameter logic [DATA_WIDTH-1:0]  DATA_SEED  = 4'b1000,
  parameter int NOISE_WIDTH = 12,
  parameter logic [NOISE_WIDTH-1:0] NOISE_TAPS = 12'h829,
  parameter logic [NOISE_WIDTH-1:0] NOISE_SEED = 12'h800
) (
  input  logic     clk,
  input  logic     rst,
  input  strobes_t stb,
  input  logic     phase,
  output logic     dataBit,
  output logic     lineBit,
  output logic     noiseBit
);
  prbs_manch_lfsr #(.WIDTH(DATA_WIDTH), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_data (
    .clk(clk), .rst(rst), .shiftEn(stb.advance), .msb(dataBit)
  );

  prbs_manch_lfsr #(.WIDTH(NOISE_WIDTH), .TAPS(NOISE_TAPS), .SEED(NOISE_SEED)) u_noise (
    .clk(clk), .rst(rst), .shiftEn(stb.advance), .msb(noiseBit)
  );

  // first half carries the bit, second half its complement
  assign lineBit = dataBit ^ phase;

  AST_ADV_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    stb.advance |-> stb.toggle); // R4
endmodule

// File: rtl/prbs_manch_src.sv
module prbs_manch_src
  import prbs_manch_pkg::*;
#(
  parameter int DATA_WIDTH  = 4,
  parameter logic [DATA_WIDTH-1:0]  DATA_TAPS  = 4'b1100,
  parameter logic [DATA_WIDTH-1:0]  DATA_SEED  = 4'b1000,
  parameter int NOISE_WIDTH = 12,
  parameter logic [NOISE_WIDTH-1:0] NOISE_TAPS = 12'h829,
  parameter logic [NOISE_WIDTH-1:0] NOISE_SEED = 12'h800
) (
  input  logic clk,
  input  logic rst,
  input  logic halfEn,
  output logic dataOut,
  output logic lineOut,
  output logic noiseOut
);
  strobes_t stb;
  logic     phase;

  prbs_manch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .halfEn(halfEn), .stb(stb), .phase(phase)
  );

  prbs_manch_dp #(
    .DATA_WIDTH(DATA_WIDTH), .DATA_TAPS(DATA_TAPS), .DATA_SEED(DATA_SEED),
    .NOISE_WIDTH(NOISE_WIDTH), .NOISE_TAPS(NOISE_TAPS), .NOISE_SEED(NOISE_SEED)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .phase(phase),
    .dataBit(dataOut), .lineBit(lineOut), .noiseBit(noiseOut)
  );

  AST_MID_FLIP: assert property (@(posedge clk) disable iff (rst)
    (stb.toggle && !stb.advance) |=> (lineOut != $past(lineOut)) && $stable(dataOut)); // R3
  AST_MID_NOISE_STILL: assert property (@(posedge clk) disable iff (rst)
    (stb.toggle && !stb.advance) |=> $stable(noiseOut)); // R4
endmodule

// File: tb/prbs_manch_src_bench.sv
module prbs_manch_src_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halfEn = 1'b0;
  logic dataOut, lineOut, noiseOut;

  int errors = 0;
  int checks = 0;

  localparam int NBITS = 4111;
  localparam bit EXP_DATA [0:14] = '{1,0,0,0,1,0,0,1,1,0,1,0,1,1,1};

  always #2 clk = ~clk; // 250 MHz

  prbs_manch_src u_prbs_manch_src (
    .clk(clk), .rst(rst), .halfEn(halfEn),
    .dataOut(dataOut), .lineOut(lineOut), .noiseOut(noiseOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one halfEn pulse; returns at the falling edge after the update
  task automatic tick();
    @(negedge clk); halfEn = 1'b1;
    @(negedge clk); halfEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  bit dSeq [0:NBITS-1];
  bit nSeq [0:NBITS-1];

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(dataOut == 1'b1, "R1 dataOut", dataOut, 1);
    chk(noiseOut == 1'b1, "R1 noiseOut", noiseOut, 1);
    chk(lineOut == 1'b1, "R1 lineOut", lineOut, 1);

    // table walk: R2 data order, R3 line halves
    for (int b = 0; b < 15; b++) begin
      chk(dataOut == EXP_DATA[b], "R2 data bit", dataOut, EXP_DATA[b]);
      chk(lineOut == EXP_DATA[b], "R3 first half", lineOut, EXP_DATA[b]);
      tick();
      chk(lineOut == !EXP_DATA[b], "R3 second half", lineOut, !EXP_DATA[b]);
      chk(dataOut == EXP_DATA[b], "R4 data held mid-bit", dataOut, EXP_DATA[b]);
      tick();
    end
    chk(dataOut == EXP_DATA[0], "R2 period 15", dataOut, EXP_DATA[0]);

    // R5 idle in the second half
    tick();
    begin
      bit d0, l0, n0;
      d0 = dataOut; l0 = lineOut; n0 = noiseOut;
      repeat (20) @(negedge clk);
      chk(dataOut == d0, "R5 data hold", dataOut, d0);
      chk(lineOut == l0, "R5 line hold", lineOut, l0);
      chk(noiseOut == n0, "R5 noise hold", noiseOut, n0);
    end

    // R7 reset mid-bit wins over halfEn
    @(negedge clk); rst = 1'b1; halfEn = 1'b1;
    @(negedge clk); rst = 1'b0; halfEn = 1'b0;
    chk(dataOut == 1'b1, "R7 data seed", dataOut, 1);
    chk(noiseOut == 1'b1, "R7 noise seed", noiseOut, 1);
    chk(lineOut == 1'b1, "R7 first half", lineOut, 1);
    tick();
    chk(lineOut == 1'b0, "R7 phase restarted", lineOut, 0);
    chk(dataOut == 1'b1, "R7 data after half", dataOut, 1);

    // long run: R2, R4, R6, R8
    doReset();
    for (int b = 0; b < NBITS; b++) begin
      dSeq[b] = dataOut;
      nSeq[b] = noiseOut;
      chk(lineOut == dataOut, "R3 first half long", lineOut, dataOut);
      tick();
      chk(dataOut == dSeq[b], "R4 data mid", dataOut, dSeq[b]);
      chk(noiseOut == nSeq[b], "R4 noise mid", noiseOut, nSeq[b]);
      tick();
    end
    for (int k = 0; k + 4 < NBITS; k++)
      chk(dSeq[k+4] == (dSeq[k] ^ dSeq[k+1]), "R2 recurrence", dSeq[k+4], dSeq[k] ^ dSeq[k+1]);
    for (int k = 0; k + 12 < NBITS; k++)
      chk(nSeq[k+12] == (nSeq[k] ^ nSeq[k+6] ^ nSeq[k+8] ^ nSeq[k+11]), "R6 recurrence",
          nSeq[k+12], nSeq[k] ^ nSeq[k+6] ^ nSeq[k+8] ^ nSeq[k+11]);
    begin
      int ones = 0;
      int dOnes = 0;
      for (int k = 0; k < 4095; k++) ones += int'(nSeq[k]);
      for (int k = 0; k < 15; k++) dOnes += int'(dSeq[k]);
      chk(ones == 2048, "R6 ones per period", ones, 2048);
      chk(dOnes == 8, "R2 ones per period", dOnes, 8);
    end
    for (int k = 0; k < 16; k++)
      chk(nSeq[k+4095] == nSeq[k], "R6 period 4095", nSeq[k+4095], nSeq[k]);
    // R8: an all-zero register would emit zeros forever
    begin
      int run = 0;
      int maxRun = 0;
      for (int k = 0; k < NBITS; k++) begin
        run = nSeq[k] ? 0 : run + 1;
        if (run > maxRun) maxRun = run;
      end
      chk(maxRun <= 11, "R8 noise zero run", maxRun, 11);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule